// File: doc/BRIEF.md
# Prefixed Instruction Length Classifier

This block sits in an instruction fetch path and takes in a stream of 32-bit words over a valid/ready handshake. Each instruction is either one word long or two words long. The block decides the length from the major opcode and, for the escape opcode 9, from two selector bits in the first word. For two-word instructions it keeps the first word in a holding register until the second word arrives. It then joins the two words into one record. Bit numbering is most-significant-first: bit 0 of a word is its top bit.

Each record carries the following fields:
- the instruction bits, left-aligned in a 64-bit field;
- a length flag;
- a 3-bit class code;
- the 24-bit prefix field taken from bits 6-29 of the first word;
- a 2-bit extension-area code.

Records leave through a registered output stage with its own valid/ready handshake. A synchronous flush throws away a half-assembled instruction and any record that has not yet been taken.

Class codes:
- 0: plain 32-bit
- 1: scalar 64-bit
- 2: single-prefixed
- 3: vector-prefixed
- 4: reserved
- 5: other 64-bit (opcode 1)

Area codes:
- 0: base opcode space
- 1: the opcode-9 private 32-bit space, called EXT900
- 2: the EXT200-231 area
- 3: the opcode-1 prefixed space

Top module: `insn_len_classifier`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: A word whose major opcode (bits 0-5) is neither 1 nor 9 yields a one-word record: length flag 0, class 0, area 0, prefix 0, out_insn[63:32] = the word, out_insn[31:0] = 0.
- R3: Opcode 9 with bits 30:31 = 00 yields a one-word record with class 0 and area 1.
- R4: Opcode 1 always forms a two-word record with class 5 and area 3, and its prefix is bits 6-29 of the first word.
- R5: Opcode 9 with bits 30:31 = 01 forms a two-word record in area 0. The class is 1 if the prefix field is zero and 2 otherwise.
- R6: Opcode 9 with bits 30:31 = 11 forms a two-word record with class 3 and area 0.
- R7: Opcode 9 with bits 30:31 = 10, with bit 32 = 0 and bits 33-37 = 10001 (the high bits of the second word), gives area 1. The class depends on bits 62-63 (the low two bits of the second word):
  - 01: class 3;
  - 00: class 2 if the prefix field is nonzero, class 4 if it is zero;
  - 10 or 11: class 4.
- R8: Opcode 9 with bits 30:31 = 10 outside the R7 pattern gives area 2. If bit 32 = 1 the class is 3. Otherwise the class is 2 if the prefix field is nonzero and 1 if it is zero.
- R9: A two-word record appears only after its second word is accepted, with out_insn = {first, second} and length flag 1. in_valid going low between the two words only delays it.
- R10: While out_valid is 1 and out_ready is 0, every output field holds steady and in_ready is 0, so no input word is lost.
- R11: While flush is high, in_ready is 0. In the cycle after a flush, out_valid is 0 and the held first word is discarded, so the next word is treated as a new instruction start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop the held first word and the pending record |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_word | input | 32 | Instruction word, bit 0 = MSB |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_insn | output | 64 | Instruction bits, left-aligned |
| out_is64 | output | 1 | 1 for a two-word instruction |
| out_class | output | 3 | Class code |
| out_prefix | output | 24 | Prefix field, zero for one-word records |
| out_area | output | 2 | Extension-area code |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 6-bit opcode, escape opcode 9, long opcode 1 and escape pattern 10001. These values place every selector value, every sub-form value and the two prefix cases (zero and nonzero) inside a short vector table. With these values, the escape pattern with bit 32 set can be shown to fall into area 2 rather than area 1. Directed cases then cover a gap in in_valid between the two words, a held record under back-pressure with a blocked input, and flushes both with a half-held instruction and with a pending record.

// File: rtl/il_pkg.sv
package il_pkg;
  localparam int WORD_W   = 32;
  localparam int OPC_W    = 6;
  localparam int SEL_W    = 2;
  localparam int SUB_W    = 2;
  localparam int ESC_W    = 5;
  localparam int PFX_W    = WORD_W - OPC_W - SEL_W;
  localparam int INSN_W   = 2 * WORD_W;
  localparam logic [OPC_W-1:0] OP_LONG = OPC_W'(1);
  localparam logic [OPC_W-1:0] OP_ESC  = OPC_W'(9);
  localparam logic [ESC_W-1:0] ESC_PAT = 5'b10001;

  typedef enum logic [2:0] {
    CL_PLAIN  = 3'd0,
    CL_SCALAR = 3'd1,
    CL_SINGLE = 3'd2,
    CL_VECTOR = 3'd3,
    CL_RSVD   = 3'd4,
    CL_LONG   = 3'd5
  } cls_e;

  typedef enum logic [1:0] {
    AR_BASE = 2'd0,
    AR_X900 = 2'd1,
    AR_X200 = 2'd2,
    AR_LONG = 2'd3
  } area_e;

  typedef struct packed {
    logic [INSN_W-1:0] insn;
    logic              is64;
    cls_e              cls;
    logic [PFX_W-1:0]  pfx;
    area_e             area;
  } rec_t;
endpackage

// File: rtl/il_first_decode.sv
module il_first_decode
  import il_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [SEL_W-1:0] sel,
  output logic             need_second,
  output area_e            area
);
  always_comb begin
    need_second = 1'b0;
    area        = AR_BASE;
    if (opc == OP_LONG) begin
      need_second = 1'b1;
      area        = AR_LONG;
    end else if (opc == OP_ESC) begin
      if (sel == '0) area = AR_X900;
      else           need_second = 1'b1;
    end
  end
endmodule

// File: rtl/il_pair_classify.sv
module il_pair_classify
  import il_pkg::*;
(
  input  logic [WORD_W-1:0] first,
  input  logic              b32,
  input  logic [ESC_W-1:0]  esc,
  input  logic [SUB_W-1:0]  sub,
  output cls_e              cls,
  output area_e             area,
  output logic [PFX_W-1:0]  pfx
);
  logic [OPC_W-1:0] opc;
  logic [SEL_W-1:0] sel;
  logic             pfx_nz;
  logic             esc_hit;

  assign opc     = first[WORD_W-1 -: OPC_W];
  assign sel     = first[SEL_W-1:0];
  assign pfx     = first[WORD_W-OPC_W-1 : SEL_W];
  assign pfx_nz  = |pfx;
  assign esc_hit = !b32 && (esc == ESC_PAT);

  always_comb begin
    cls  = CL_RSVD;
    area = AR_BASE;
    if (opc != OP_ESC) begin
      cls  = CL_LONG;
      area = AR_LONG;
    end else begin
      case (sel)
        2'b01: begin
          area = AR_BASE;
          cls  = pfx_nz ? CL_SINGLE : CL_SCALAR;
        end
        2'b11: begin
          area = AR_BASE;
          cls  = CL_VECTOR;
        end
        2'b10: begin
          if (esc_hit) begin
            area = AR_X900;
            case (sub)
              2'b01:   cls = CL_VECTOR;
              2'b00:   cls = pfx_nz ? CL_SINGLE : CL_RSVD;
              default: cls = CL_RSVD;
            endcase
          end else begin
            area = AR_X200;
            if (b32)         cls = CL_VECTOR;
            else if (pfx_nz) cls = CL_SINGLE;
            else             cls = CL_SCALAR;
          end
        end
        default: begin
          area = AR_X900;
          cls  = CL_PLAIN;
        end
      endcase
    end
  end
endmodule

// File: rtl/il_out_stage.sv
module il_out_stage #(
  parameter int REC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             load,
  input  logic [REC_W-1:0] rec_in,
  input  logic             take,
  output logic             valid,
  output logic [REC_W-1:0] rec_out
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_out <= '0;
    end else if (load && !flush) begin
      rec_out <= rec_in;
    end
  end
endmodule

// File: rtl/insn_len_classifier.sv
module insn_len_classifier
  import il_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [INSN_W-1:0] out_insn,
  output logic              out_is64,
  output logic [2:0]        out_class,
  output logic [PFX_W-1:0]  out_prefix,
  output logic [1:0]        out_area
);
  localparam int REC_W = $bits(rec_t);

  logic              holding;
  logic [WORD_W-1:0] hold_word;
  logic              accept;
  logic              need_second;
  logic              load_out;
  area_e             area_one;
  cls_e              cls_two;
  area_e             area_two;
  logic [PFX_W-1:0]  pfx_two;
  rec_t              rec_next;
  rec_t              rec_q;
  logic [REC_W-1:0]  rec_bits;

  assign in_ready = !flush && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  il_first_decode u_first (
    .opc         (in_word[WORD_W-1 -: OPC_W]),
    .sel         (in_word[SEL_W-1:0]),
    .need_second (need_second),
    .area        (area_one)
  );

  il_pair_classify u_pair (
    .first (hold_word),
    .b32   (in_word[WORD_W-1]),
    .esc   (in_word[WORD_W-2 -: ESC_W]),
    .sub   (in_word[SUB_W-1:0]),
    .cls   (cls_two),
    .area  (area_two),
    .pfx   (pfx_two)
  );

  assign load_out = accept && (holding || !need_second);

  always_comb begin
    if (holding) begin
      rec_next.insn = {hold_word, in_word};
      rec_next.is64 = 1'b1;
      rec_next.cls  = cls_two;
      rec_next.pfx  = pfx_two;
      rec_next.area = area_two;
    end else begin
      rec_next.insn = {in_word, {WORD_W{1'b0}}};
      rec_next.is64 = 1'b0;
      rec_next.cls  = CL_PLAIN;
      rec_next.pfx  = '0;
      rec_next.area = area_one;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      holding <= 1'b0;
    end else if (accept) begin
      holding <= !holding && need_second;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word <= '0;
    end else if (accept && !holding && need_second) begin
      hold_word <= in_word;
    end
  end

  il_out_stage #(.REC_W(REC_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .load    (load_out),
    .rec_in  (rec_next),
    .take    (out_ready),
    .valid   (out_valid),
    .rec_out (rec_bits)
  );

  assign rec_q      = rec_t'(rec_bits);
  assign out_insn   = rec_q.insn;
  assign out_is64   = rec_q.is64;
  assign out_class  = rec_q.cls;
  assign out_prefix = rec_q.pfx;
  assign out_area   = rec_q.area;
endmodule

// File: rtl/il_checker.sv
module il_checker
  import il_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [INSN_W-1:0] out_insn,
  input logic              out_is64,
  input logic [2:0]        out_class,
  input logic [PFX_W-1:0]  out_prefix,
  input logic [1:0]        out_area
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  one_word_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is64) |-> (out_class == 3'd0 && out_prefix == '0 && out_insn[WORD_W-1:0] == '0));

  // R4
  long_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 3'd5) |-> (out_is64 && out_area == 2'd3 && out_insn[INSN_W-1 -: OPC_W] == OP_LONG));

  // R9
  two_word_class_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is64) |-> (out_class != 3'd0 && out_class <= 3'd5));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_insn) && $stable(out_class) && $stable(out_area) && $stable(out_prefix)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);

  // R11
  flush_block_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready);
endmodule

bind insn_len_classifier il_checker chk (.*);

// File: tb/insn_len_classifier_test.sv
`timescale 1ns/1ps
module insn_len_classifier_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_insn;
  logic        out_is64;
  logic [2:0]  out_class;
  logic [23:0] out_prefix;
  logic [1:0]  out_area;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  insn_len_classifier uut (.*);

  typedef struct packed {
    logic [31:0] w0;
    logic [31:0] w1;
    logic        is64;
    logic [2:0]  cls;
    logic [1:0]  area;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{32'h38001234, 32'h0,        1'b0, 3'd0, 2'd0, 4'd2},  // R2 opcode 14
    '{32'h00000000, 32'h0,        1'b0, 3'd0, 2'd0, 4'd2},  // R2 opcode 0
    '{32'h24ABCDE0, 32'h0,        1'b0, 3'd0, 2'd1, 4'd3},  // R3
    '{32'h0448D15B, 32'hDEADBEEF, 1'b1, 3'd5, 2'd3, 4'd4},  // R4
    '{32'h24000001, 32'h7C000000, 1'b1, 3'd1, 2'd0, 4'd5},  // R5 zero prefix
    '{32'h24000005, 32'h7C000000, 1'b1, 3'd2, 2'd0, 4'd5},  // R5 nonzero prefix
    '{32'h26AF37BF, 32'h12345678, 1'b1, 3'd3, 2'd0, 4'd6},  // R6
    '{32'h24000002, 32'h44000001, 1'b1, 3'd3, 2'd1, 4'd7},  // R7 sub 01
    '{32'h24000006, 32'h44000000, 1'b1, 3'd2, 2'd1, 4'd7},  // R7 sub 00 nonzero
    '{32'h24000002, 32'h44000000, 1'b1, 3'd4, 2'd1, 4'd7},  // R7 sub 00 zero
    '{32'h24000006, 32'h44000002, 1'b1, 3'd4, 2'd1, 4'd7},  // R7 sub 10
    '{32'h24000006, 32'h44000003, 1'b1, 3'd4, 2'd1, 4'd7},  // R7 sub 11
    '{32'h24000002, 32'h80000000, 1'b1, 3'd3, 2'd2, 4'd8},  // R8 bit32 set
    '{32'h24000002, 32'hC4000000, 1'b1, 3'd3, 2'd2, 4'd8},  // R8 bit32 set with pattern
    '{32'h24000006, 32'h48000000, 1'b1, 3'd2, 2'd2, 4'd8},  // R8 nonzero prefix
    '{32'h24000002, 32'h48000000, 1'b1, 3'd1, 2'd2, 4'd8},  // R8 zero prefix
    '{32'h27FFFFFD, 32'h00000001, 1'b1, 3'd2, 2'd0, 4'd5}   // R5 full prefix
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic check_rec(input string tag, input logic [31:0] w0, input logic [31:0] w1,
                           input logic is64, input logic [2:0] cls, input logic [1:0] area);
    logic [63:0] exp_insn;
    logic [23:0] exp_pfx;
    exp_insn = is64 ? {w0, w1} : {w0, 32'h0};
    exp_pfx  = is64 ? w0[25:2] : 24'h0;
    @(negedge clk);
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " insn"}, out_insn, exp_insn);
    chk({tag, " len"}, 64'(out_is64), 64'(is64));
    chk({tag, " class"}, 64'(out_class), 64'(cls));
    chk({tag, " area"}, 64'(out_area), 64'(area));
    chk({tag, " prefix"}, 64'(out_prefix), 64'(exp_pfx));
  endtask

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VEC[i].req, i);
      push(VEC[i].w0);
      if (VEC[i].is64) begin
        @(negedge clk);
        chk({t, " no early record"}, 64'(out_valid), 64'd0);
        push(VEC[i].w1);
      end
      check_rec(t, VEC[i].w0, VEC[i].w1, VEC[i].is64, VEC[i].cls, VEC[i].area);
    end

    // R9: gap between the two words
    push(32'h24000006);
    repeat (5) begin
      @(negedge clk);
      chk("R9 waiting", 64'(out_valid), 64'd0);
    end
    push(32'h48000000);
    check_rec("R9 after gap", 32'h24000006, 32'h48000000, 1'b1, 3'd2, 2'd2);

    // R10: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    push(32'h38000AAA);
    repeat (3) begin
      @(negedge clk);
      chk("R10 held valid", 64'(out_valid), 64'd1);
      chk("R10 held insn", out_insn, {32'h38000AAA, 32'h0});
    end
    in_valid = 1'b1;
    in_word  = 32'h3C000555;
    #0.5;
    chk("R10 input blocked", 64'(in_ready), 64'd0);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    check_rec("R10 next word", 32'h3C000555, 32'h0, 1'b0, 3'd0, 2'd0);

    // R11: flush with a held first word
    push(32'h24000006);
    @(negedge clk);
    flush = 1'b1;
    #0.5;
    chk("R11 in_ready during flush", 64'(in_ready), 64'd0);
    @(posedge clk);
    #1 flush = 1'b0;
    push(32'h38000001);
    check_rec("R11 fresh start", 32'h38000001, 32'h0, 1'b0, 3'd0, 2'd0);

    // R11: flush with a pending record
    @(negedge clk);
    out_ready = 1'b0;
    push(32'h38000002);
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1 flush = 1'b0;
    @(negedge clk);
    chk("R11 pending dropped", 64'(out_valid), 64'd0);
    out_ready = 1'b1;

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule